// File: doc/BRIEF.md
# GPIO Pin Interrupt Detector

This block turns the already synchronised input levels of a 32-pin general purpose port into per-pin interrupt events. A pin takes part only when the port register file puts it into interrupt use. Each participating pin then watches for one of four conditions:

- a rising edge;
- a falling edge;
- a high level;
- a low level.

The per-pin trigger bit chooses between edge and level detection. The per-pin direction bit chooses the polarity.

Every event sets a sticky flag for its pin. The register file reads the flag vector as a read-only word. Software clears flags by writing ones through a separate clear strobe and data word. A single registered interrupt request rises when any flag is set whose mask bit is zero.

Pad multiplexing and bus address decoding sit in neighbouring logic. This block sees only configuration vectors and a clear strobe.

Top module: `gpio_irq_detect`

## Requirements
- R1: While reset is asserted and on the first cycle after it, every flag bit and the interrupt request read 0.
- R2: A pin whose function bit is 1, or whose select bit is 0, never sets its flag, whatever its level or other configuration.
- R3: With trigger bit 1 and direction bit 1, a 0-to-1 change of the pin level between two cycles sets the flag at the clock edge that sees the new level. A 1-to-0 change does not set it.
- R4: With trigger bit 1 and direction bit 0, a 1-to-0 change of the pin level sets the flag. A 0-to-1 change does not set it.
- R5: With trigger bit 0, the flag is set at every clock edge where the pin is high (direction 1) or low (direction 0).
- R6: When the clear strobe is high, each flag whose bit in the clear data word is 1 goes to 0 at that edge. Bits written as 0, and any data presented with the strobe low, leave the flags unchanged.
- R7: The interrupt request equals, one clock later, the OR over all pins of (flag AND NOT mask).
- R8: A masked flag stays set. Clearing its mask bit without clearing the flag raises the request at the next clock edge.
- R9: When a clear and a new detection event reach the same pin at the same edge, the flag ends up set.
- R10: Edge detection is suppressed on the first cycle in which a pin enters interrupt use. A level change in that cycle sets no flag, and later edges are detected normally.
- R11: A set flag stays set after its condition disappears and after the pin leaves interrupt use, until it is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_lvl_i | input | 32 | Synchronised pin levels |
| func_i | input | 32 | Per-pin function bit (1 = peripheral function) |
| sel_i | input | 32 | Per-pin select bit (1 with function 0 = interrupt use) |
| dir_i | input | 32 | Per-pin direction bit, reused as polarity (1 = high/rising) |
| trig_i | input | 32 | Per-pin trigger bit (1 = edge, 0 = level) |
| mask_i | input | 32 | Per-pin mask (1 = blocked from the request) |
| clr_we_i | input | 1 | Clear strobe for the flag register |
| clr_data_i | input | 32 | Write-one-to-clear data |
| flag_o | output | 32 | Sticky flag vector |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The assertions check several properties on every cycle:

- A flag only ever falls at an edge where the clear strobe carried a one for it.
- A flag only ever rises on a pin that was in interrupt use.
- An asserted level condition always leaves the flag set, even against a simultaneous clear.
- The request tracks the unmasked flags with one cycle of lag.

Some behaviours need a prepared history, so only the directed scenarios can show them: edge polarity, suppression of an edge in the cycle a pin enters interrupt use, an edge racing a clear, and a stale event delivered when a pin is unmasked.

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int NPINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_lvl_i,
  input  logic [NPINS-1:0] func_i,
  input  logic [NPINS-1:0] sel_i,
  input  logic [NPINS-1:0] dir_i,
  input  logic [NPINS-1:0] trig_i,
  input  logic [NPINS-1:0] mask_i,
  input  logic             clr_we_i,
  input  logic [NPINS-1:0] clr_data_i,
  output logic [NPINS-1:0] flag_o,
  output logic             irq_o
);

  logic [NPINS-1:0] lvl_q;
  logic [NPINS-1:0] en_q;
  logic [NPINS-1:0] flag_q;
  logic             irq_q;

  logic [NPINS-1:0] en;
  logic [NPINS-1:0] armed;
  logic [NPINS-1:0] rise;
  logic [NPINS-1:0] fall;
  logic [NPINS-1:0] edge_hit;
  logic [NPINS-1:0] level_hit;
  logic [NPINS-1:0] clr;
  logic [NPINS-1:0] flag_d;

  // interrupt use: not a peripheral function, select set
  assign en    = ~func_i & sel_i;
  // edges count only once the pin was already in use last cycle
  assign armed = en & en_q;
  assign rise  = pin_lvl_i & ~lvl_q;
  assign fall  = ~pin_lvl_i & lvl_q;

  assign edge_hit  = trig_i & armed & ((dir_i & rise) | (~dir_i & fall));
  assign level_hit = ~trig_i & en & ~(dir_i ^ pin_lvl_i);

  assign clr    = clr_we_i ? clr_data_i : '0;
  assign flag_d = (flag_q & ~clr) | edge_hit | level_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q  <= '0;
      en_q   <= '0;
      flag_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      lvl_q  <= pin_lvl_i;
      en_q   <= en;
      flag_q <= flag_d;
      irq_q  <= |(flag_q & ~mask_i);
    end
  end

  assign flag_o = flag_q;
  assign irq_o  = irq_q;

endmodule

// File: rtl/gpio_irq_detect_chk.sv
module gpio_irq_detect_chk #(
  parameter int NPINS = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NPINS-1:0] pin_lvl_i,
  input logic [NPINS-1:0] func_i,
  input logic [NPINS-1:0] sel_i,
  input logic [NPINS-1:0] dir_i,
  input logic [NPINS-1:0] trig_i,
  input logic [NPINS-1:0] mask_i,
  input logic             clr_we_i,
  input logic [NPINS-1:0] clr_data_i,
  input logic [NPINS-1:0] flag_o,
  input logic             irq_o
);

  logic [NPINS-1:0] in_use;
  logic [NPINS-1:0] lvl_cond;
  logic [NPINS-1:0] clr_bits;
  logic             pend;

  assign in_use   = ~func_i & sel_i;
  assign lvl_cond = in_use & ~trig_i & ~(dir_i ^ pin_lvl_i);
  assign clr_bits = clr_we_i ? clr_data_i : '0;
  assign pend     = |(flag_o & ~mask_i);

  // R6
  flag_fall_needs_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(flag_o) & ~flag_o) & ~$past(clr_bits)) == '0));

  // R2
  flag_rise_needs_use_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((flag_o & ~$past(flag_o)) & ~$past(in_use)) == '0));

  // R5
  level_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(lvl_cond) & ~flag_o) == '0));

  // R7
  irq_rises_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend |=> irq_o);

  // R7
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pend |=> !irq_o);

endmodule

bind gpio_irq_detect gpio_irq_detect_chk #(.NPINS(NPINS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pin_lvl_i  (pin_lvl_i),
  .func_i     (func_i),
  .sel_i      (sel_i),
  .dir_i      (dir_i),
  .trig_i     (trig_i),
  .mask_i     (mask_i),
  .clr_we_i   (clr_we_i),
  .clr_data_i (clr_data_i),
  .flag_o     (flag_o),
  .irq_o      (irq_o)
);

// File: tb/gpio_irq_detect_tb.sv
module gpio_irq_detect_tb;
  localparam int CLK_P = 10;
  localparam int N = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] lvl = '0, fn = '0, sl = '0, dr = '0, tg = '0, mk = '0, cdat = '0;
  logic         cwe = 1'b0;
  logic [N-1:0] flag;
  logic         irq;

  int tests = 0;
  int fails = 0;

  always #(CLK_P/2) clk = ~clk;

  gpio_irq_detect #(.NPINS(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .pin_lvl_i(lvl), .func_i(fn), .sel_i(sl),
    .dir_i(dr), .trig_i(tg), .mask_i(mk), .clr_we_i(cwe), .clr_data_i(cdat),
    .flag_o(flag), .irq_o(irq)
  );

  task automatic step(input int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic pulse_clear(input logic [N-1:0] m);
    cwe = 1'b1; cdat = m;
    step();
    cwe = 1'b0; cdat = '0;
  endtask

  task automatic cleanup();
    fn = '0; sl = '0; dr = '0; tg = '0; mk = '0; lvl = '0;
    pulse_clear('1);
    step();
  endtask

  task automatic t_reset();
    step(3);
    chk("R1 flags in reset", flag, '0);
    chk("R1 irq in reset", {31'd0, irq}, '0);
    rst_n = 1'b1;
    step();
    chk("R1 flags after reset", flag, '0);
    chk("R1 irq after reset", {31'd0, irq}, '0);
  endtask

  task automatic t_disabled();
    fn[3] = 1'b1; sl[3] = 1'b1; dr[3] = 1'b1; lvl[3] = 1'b1;
    sl[4] = 1'b0; dr[4] = 1'b1; lvl[4] = 1'b1;
    step(3);
    lvl[3] = 1'b0; lvl[4] = 1'b0; tg[3] = 1'b1; tg[4] = 1'b1;
    step(2);
    lvl[3] = 1'b1; lvl[4] = 1'b1;
    step(2);
    chk("R2 disabled pins stay clear", flag, '0);
    cleanup();
  endtask

  task automatic t_rise();
    sl[5] = 1'b1; tg[5] = 1'b1; dr[5] = 1'b1;
    step(3);
    chk("R3 no edge yet", flag, '0);
    lvl[5] = 1'b1;
    step();
    chk("R3 rising edge sets flag", flag, 32'h1 << 5);
    chk("R7 irq lags flag", {31'd0, irq}, '0);
    step();
    chk("R7 irq follows unmasked flag", {31'd0, irq}, 32'd1);
    pulse_clear(32'h1 << 5);
    lvl[5] = 1'b0;
    step(2);
    chk("R3 falling edge ignored", flag, '0);
    cleanup();
  endtask

  task automatic t_fall();
    sl[7] = 1'b1; tg[7] = 1'b1; dr[7] = 1'b0;
    step(3);
    lvl[7] = 1'b1;
    step(2);
    chk("R4 rising edge ignored", flag, '0);
    lvl[7] = 1'b0;
    step();
    chk("R4 falling edge sets flag", flag, 32'h1 << 7);
    cleanup();
  endtask

  task automatic t_level();
    sl[9] = 1'b1; dr[9] = 1'b1;
    sl[10] = 1'b1; dr[10] = 1'b0; lvl[10] = 1'b1;
    step(3);
    chk("R5 no level condition", flag, '0);
    lvl[9] = 1'b1;
    step();
    chk("R5 high level sets flag", flag, 32'h1 << 9);
    lvl[9] = 1'b0;
    step(2);
    chk("R11 flag sticky after level drops", flag, 32'h1 << 9);
    lvl[10] = 1'b0;
    step();
    chk("R5 low level sets flag", flag, (32'h1 << 9) | (32'h1 << 10));
    cleanup();
  endtask

  task automatic t_clear();
    sl[20] = 1'b1; dr[20] = 1'b1; sl[21] = 1'b1; dr[21] = 1'b1;
    lvl[20] = 1'b1; lvl[21] = 1'b1;
    step();
    lvl[20] = 1'b0; lvl[21] = 1'b0;
    step();
    chk("R6 both flags set", flag, (32'h1 << 20) | (32'h1 << 21));
    cdat = 32'h1 << 20;
    step();
    cdat = '0;
    chk("R6 data without strobe ignored", flag, (32'h1 << 20) | (32'h1 << 21));
    pulse_clear(32'h1 << 20);
    chk("R6 only written ones clear", flag, 32'h1 << 21);
    pulse_clear((32'h1 << 21) | (32'h1 << 25));
    chk("R6 remaining flag cleared", flag, '0);
    cleanup();
  endtask

  task automatic t_mask();
    mk[12] = 1'b1; sl[12] = 1'b1; dr[12] = 1'b1; lvl[12] = 1'b1;
    step();
    lvl[12] = 1'b0;
    step(2);
    chk("R8 masked flag held", flag, 32'h1 << 12);
    chk("R7 masked flag gives no irq", {31'd0, irq}, '0);
    mk[12] = 1'b0;
    step();
    chk("R8 unmask delivers stale event", {31'd0, irq}, 32'd1);
    pulse_clear(32'h1 << 12);
    chk("R6 flag cleared", flag, '0);
    step();
    chk("R7 irq drops after clear", {31'd0, irq}, '0);
    cleanup();
  endtask

  task automatic t_race();
    sl[14] = 1'b1; dr[14] = 1'b1; lvl[14] = 1'b1;
    sl[15] = 1'b1; dr[15] = 1'b1; tg[15] = 1'b1;
    step(3);
    chk("R9 level flag set", flag, 32'h1 << 14);
    pulse_clear(32'h1 << 14);
    chk("R9 level event beats clear", flag, 32'h1 << 14);
    lvl[15] = 1'b1;
    step();
    lvl[15] = 1'b0;
    step();
    chk("R3 edge flag set", flag, (32'h1 << 14) | (32'h1 << 15));
    lvl[15] = 1'b1;
    pulse_clear(32'h1 << 15);
    chk("R9 edge event beats clear", flag, (32'h1 << 14) | (32'h1 << 15));
    cleanup();
  endtask

  task automatic t_enter();
    tg[17] = 1'b1; dr[17] = 1'b1;
    step(2);
    sl[17] = 1'b1; lvl[17] = 1'b1;
    step(3);
    chk("R10 edge on entry suppressed", flag, '0);
    lvl[17] = 1'b0;
    step();
    lvl[17] = 1'b1;
    step();
    chk("R10 later edge detected", flag, 32'h1 << 17);
    sl[17] = 1'b0;
    step(2);
    chk("R11 flag kept after leaving use", flag, 32'h1 << 17);
    cleanup();
  endtask

  initial begin
    t_reset();
    t_disabled();
    t_rise();
    t_fall();
    t_level();
    t_clear();
    t_mask();
    t_race();
    t_enter();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule